// File: doc/BRIEF.md
# Metaframe Receive Status Checker

This block sits on the receive path behind a block aligner that already delivers whole words. Each word arrives with a two-bit kind tag that marks it as a sync word, a diagnostic word or an ordinary word. The block finds the metaframe rhythm by counting sync words that recur at the expected period, and declares frame lock. While locked it reports the start of each metaframe and checks the CRC-32 carried in the diagnostic word that closes each metaframe. It latches the remote lane and link status bits from diagnostic words that pass the check.

All outputs are registered and change on the clock edge after the word that causes them. When the lower-layer block lock drops, the block forgets everything and holds its outputs low.

Top module: `mf_rx_status`

## Requirements
- R1: While rst_n is low, frame_start, frame_lock, crc_err and lane_link read zero.
- R2: Word kinds are 2'b01 sync, 2'b10 diagnostic, and any other value ordinary. When unlocked, a sync word opens a candidate. frame_lock rises on the edge after the 4th sync word that arrives at consecutive expected positions, MF_LEN valid words apart. A non-sync word at an expected position drops the candidate.
- R3: While locked, frame_lock stays high through up to 2 consecutive missing sync words at expected positions. It falls on the edge after the 3rd consecutive miss. A sync word at the expected position resets the miss count.
- R4: frame_start is high for exactly FS_HOLD (3) cycles. It starts on the edge after each sync word accepted at the expected position while locked, and after the sync word that completes lock.
- R5: The diagnostic word is expected at the last position of the metaframe (index MF_LEN-1). When it arrives there with the diagnostic kind, while locked and with a matching CRC, lane_link takes word bits [33:32]: bit 1 is lane up and bit 0 is link up.
- R6: lane_link keeps its value after a diagnostic word that fails the CRC, after one received while unlocked, and after a last-position word not tagged diagnostic.
- R7: The check value is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, with no reflection and no final inversion. It is computed MSB first (bit 63 of each word first) over every word from the sync word through the diagnostic word, with the diagnostic word's bits [31:0] replaced by zero. It is compared with the diagnostic word's bits [31:0].
- R8: A CRC mismatch at a diagnostic word received while locked drives crc_err high for exactly ERR_HOLD (3) cycles, starting on the next edge. A match leaves crc_err low.
- R9: While blk_lock is low, all outputs read zero from the next edge on and lock state is cleared, so a fresh lock needs 4 sync words again.
- R10: A cycle with word_vld low is ignored: it neither advances the metaframe position nor counts as a missing sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_lock | input | 1 | Lower-layer block alignment achieved |
| word_vld | input | 1 | word_data and word_kind carry a word this cycle |
| word_kind | input | 2 | 01 sync, 10 diagnostic, otherwise ordinary |
| word_data | input | DW (64) | Received word payload |
| frame_start | output | 1 | Stretched start-of-metaframe indication |
| frame_lock | output | 1 | Metaframe delineation achieved |
| lane_link | output | 2 | Latched remote status: bit 1 lane up, bit 0 link up |
| crc_err | output | 1 | Stretched CRC mismatch indication |

## Verification
A scoreboard compares every output on every cycle against a model written from the requirements. The stimulus first runs clean metaframes, which show lock acquisition and status latching. Frames with a corrupted CRC field separate a true mismatch from a status update, and frames with idle gaps show that position counting follows valid words and not cycles. Runs of two and then three missing sync words separate the tolerated case from loss of lock. Diagnostic words sent while unlocked, or tagged as ordinary words, show that status is held. A block-lock drop followed by relocking confirms that all state is cleared.

// File: rtl/mf_rx_status.sv
module mf_rx_status #(
  parameter int DW       = 64,
  parameter int MF_LEN   = 8,
  parameter int LOCK_N   = 4,
  parameter int LOSE_N   = 3,
  parameter int FS_HOLD  = 3,
  parameter int ERR_HOLD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_lock,
  input  logic          word_vld,
  input  logic [1:0]    word_kind,
  input  logic [DW-1:0] word_data,
  output logic          frame_start,
  output logic          frame_lock,
  output logic [1:0]    lane_link,
  output logic          crc_err
);
  localparam int PW = $clog2(MF_LEN);
  localparam int SW = $clog2(LOCK_N + 1);
  localparam int MW = $clog2(LOSE_N + 1);
  localparam int FW = $clog2(FS_HOLD + 1);
  localparam int EW = $clog2(ERR_HOLD + 1);
  localparam logic [1:0] K_SYNC = 2'b01;
  localparam logic [1:0] K_DIAG = 2'b10;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [DW-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [PW-1:0] pos;
  logic [SW-1:0] sync_cnt;
  logic [MW-1:0] miss;
  logic [FW-1:0] fs_cnt;
  logic [EW-1:0] err_cnt;
  logic [31:0]   crc;
  logic          locked;
  logic [1:0]    status;

  wire is_sync = word_kind == K_SYNC;
  wire is_diag = word_kind == K_DIAG;
  wire at_last = pos == PW'(MF_LEN - 1);
  wire [31:0] crc_diag = crc_step(crc, {word_data[DW-1:32], 32'h0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; sync_cnt <= '0; miss <= '0; fs_cnt <= '0;
      err_cnt <= '0; crc <= '1; locked <= 1'b0; status <= 2'b00;
    end else if (!blk_lock) begin
      pos <= '0; sync_cnt <= '0; miss <= '0; fs_cnt <= '0;
      err_cnt <= '0; crc <= '1; locked <= 1'b0; status <= 2'b00;
    end else begin
      if (fs_cnt != '0) fs_cnt <= fs_cnt - 1'b1;
      if (err_cnt != '0) err_cnt <= err_cnt - 1'b1;
      if (word_vld) begin
        if (!locked && sync_cnt == '0) begin
          if (is_sync) begin
            sync_cnt <= SW'(1);
            pos      <= PW'(1);
            crc      <= crc_step('1, word_data);
          end
        end else begin
          pos <= at_last ? '0 : pos + 1'b1;
          if (pos == '0) begin
            crc <= crc_step('1, word_data);
            if (is_sync) begin
              if (locked) begin
                miss   <= '0;
                fs_cnt <= FW'(FS_HOLD);
              end else if (sync_cnt == SW'(LOCK_N - 1)) begin
                locked <= 1'b1;
                fs_cnt <= FW'(FS_HOLD);
              end else begin
                sync_cnt <= sync_cnt + 1'b1;
              end
            end else if (locked) begin
              if (miss == MW'(LOSE_N - 1)) begin
                locked <= 1'b0; sync_cnt <= '0; miss <= '0;
              end else begin
                miss <= miss + 1'b1;
              end
            end else begin
              sync_cnt <= '0;
            end
          end else begin
            crc <= crc_step(crc, word_data);
            if (at_last && locked && is_diag) begin
              if (crc_diag == word_data[31:0]) status <= word_data[33:32];
              else err_cnt <= EW'(ERR_HOLD);
            end
          end
        end
      end
    end
  end

  assign frame_start = fs_cnt != '0;
  assign frame_lock  = locked;
  assign lane_link   = status;
  assign crc_err     = err_cnt != '0;

  p_quiet_no_blk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_lock |=> (!frame_start && !frame_lock && !crc_err && lane_link == 2'b00));

  p_lock_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_lock) |-> $past(word_vld && word_kind == K_SYNC));

  p_start_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_start) |-> $past(word_vld && word_kind == K_SYNC));

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_lock && !(word_vld && word_kind == K_DIAG)) |=> $stable(lane_link));

  p_err_after_diag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(word_vld && word_kind == K_DIAG && frame_lock));

  p_status_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_lock && !frame_lock) |=> $stable(lane_link));
endmodule

// File: tb/mf_rx_status_tb.sv
module mf_rx_status_tb;
  localparam int MF = 8;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic clk = 1'b0, rst_n = 1'b0, blk_lock = 1'b0, word_vld = 1'b0;
  logic [1:0] word_kind = 2'b00;
  logic [63:0] word_data = '0;
  logic frame_start, frame_lock, crc_err;
  logic [1:0] lane_link;

  int checks = 0, errors = 0, cycles = 0;
  logic [4:0] exp_q[$];
  logic [4:0] e;

  // model state
  bit m_lk; int m_sc, m_pos, m_miss, m_fs, m_ec; logic [1:0] m_st; logic [31:0] m_crc;

  always #10 clk = ~clk;

  mf_rx_status #(.DW(64), .MF_LEN(MF), .LOCK_N(4), .LOSE_N(3), .FS_HOLD(3), .ERR_HOLD(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_lock(blk_lock), .word_vld(word_vld),
    .word_kind(word_kind), .word_data(word_data), .frame_start(frame_start),
    .frame_lock(frame_lock), .lane_link(lane_link), .crc_err(crc_err));

  function automatic logic [31:0] crc64(input logic [31:0] c, input logic [63:0] d);
    logic [31:0] r = c;
    for (int i = 63; i >= 0; i--) begin
      logic fb = r[31] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_lk = 0; m_sc = 0; m_pos = 0; m_miss = 0; m_fs = 0; m_ec = 0; m_st = 2'b00; m_crc = '1;
  endtask

  task automatic model(input bit b, input bit v, input logic [1:0] k, input logic [63:0] d);
    if (!b) begin model_clear(); return; end
    if (m_fs > 0) m_fs--;
    if (m_ec > 0) m_ec--;
    if (!v) return;
    if (!m_lk && m_sc == 0) begin
      if (k == 2'b01) begin m_sc = 1; m_pos = 1; m_crc = crc64('1, d); end
      return;
    end
    if (m_pos == 0) begin
      m_crc = crc64('1, d);
      if (k == 2'b01) begin
        if (m_lk) begin m_miss = 0; m_fs = 3; end
        else if (m_sc == 3) begin m_lk = 1; m_fs = 3; end
        else m_sc++;
      end else if (m_lk) begin
        m_miss++;
        if (m_miss == 3) begin m_lk = 0; m_sc = 0; m_miss = 0; end
      end else m_sc = 0;
    end else begin
      if (m_pos == MF - 1 && m_lk && k == 2'b10) begin
        if (crc64(m_crc, {d[63:32], 32'h0}) == d[31:0]) m_st = d[33:32];
        else m_ec = 3;
      end
      m_crc = crc64(m_crc, d);
    end
    m_pos = (m_pos == MF - 1) ? 0 : m_pos + 1;
  endtask

  // driver: one cycle of stimulus, expected outputs pushed after the edge
  task automatic drive(input bit b, input bit v, input logic [1:0] k, input logic [63:0] d);
    @(negedge clk);
    blk_lock = b; word_vld = v; word_kind = k; word_data = d;
    @(posedge clk);
    #1;
    model(b, v, k, d);
    exp_q.push_back({m_lk, (m_fs != 0), m_st, (m_ec != 0)});
  endtask

  // one metaframe; skind is the kind at position 0, dkind at the last position
  task automatic frame(input logic [1:0] skind, input logic [1:0] dkind, input bit bad,
                       input logic [1:0] st, input bit gaps, input int seed);
    logic [31:0] c = '1;
    logic [63:0] w;
    for (int i = 0; i < MF; i++) begin
      if (i == MF - 1) begin
        w = {30'(seed * 7 + 3), st, 32'h0};
        c = crc64(c, w);
        w[31:0] = c ^ (bad ? 32'h0000_0100 : 32'h0);
        drive(1, 1, dkind, w);
      end else begin
        w = {32'(seed * 32'h9E37_79B9 + i), 32'(i * 32'h0101_0101 ^ seed)};
        c = crc64(c, w);
        drive(1, 1, (i == 0) ? skind : 2'b00, w);
        if (gaps && i == 2) begin drive(1, 0, 2'b01, 64'h0); drive(1, 0, 2'b10, 64'hFF); end
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(frame_lock == e[4], "R2/R3 frame_lock", int'(frame_lock), int'(e[4]));
      chk(frame_start == e[3], "R4 frame_start", int'(frame_start), int'(e[3]));
      chk(lane_link == e[2:1], "R5/R6 lane_link", int'(lane_link), int'(e[2:1]));
      chk(crc_err == e[0], "R7/R8 crc_err", int'(crc_err), int'(e[0]));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk(!frame_start && !frame_lock && !crc_err && lane_link == 2'b00, "R1 reset", int'(frame_lock), 0);
    rst_n = 1'b1;
    drive(1, 1, 2'b00, 64'h1);
    drive(1, 1, 2'b00, 64'h2);
    for (int n = 0; n < 4; n++) frame(2'b01, 2'b10, 0, 2'b11, 0, n);
    #2 chk(frame_lock == 1'b1, "R2 lock after four syncs", int'(frame_lock), 1);
    chk(lane_link == 2'b11, "R5 status latched", int'(lane_link), 3);
    frame(2'b01, 2'b10, 0, 2'b01, 0, 10);
    frame(2'b01, 2'b10, 1, 2'b10, 0, 11);
    #2 chk(lane_link == 2'b01, "R6 status held on bad CRC", int'(lane_link), 1);
    frame(2'b01, 2'b10, 0, 2'b10, 1, 12);
    #2 chk(lane_link == 2'b10, "R7 CRC good with gaps R10", int'(lane_link), 2);
    frame(2'b01, 2'b00, 0, 2'b11, 0, 13);
    frame(2'b00, 2'b10, 0, 2'b00, 0, 14);
    frame(2'b11, 2'b10, 0, 2'b00, 0, 15);
    frame(2'b01, 2'b10, 0, 2'b00, 0, 16);
    #2 chk(frame_lock == 1'b1, "R3 lock kept after two misses", int'(frame_lock), 1);
    for (int n = 0; n < 3; n++) frame(2'b00, 2'b10, 0, 2'b11, 0, 20 + n);
    #2 chk(frame_lock == 1'b0, "R3 lock lost after three misses", int'(frame_lock), 0);
    frame(2'b00, 2'b10, 1, 2'b11, 0, 30);
    for (int n = 0; n < 5; n++) frame(2'b01, 2'b10, 0, 2'b01, 0, 40 + n);
    drive(0, 1, 2'b01, 64'h5);
    #2 chk(!frame_lock && lane_link == 2'b00, "R9 cleared on block lock loss", int'(lane_link), 0);
    drive(0, 0, 2'b00, 64'h0);
    for (int n = 0; n < 3; n++) frame(2'b01, 2'b10, 0, 2'b10, 0, 50 + n);
    #2 chk(frame_lock == 1'b0, "R9 relock needs four syncs", int'(frame_lock), 0);
    frame(2'b01, 2'b10, 0, 2'b10, 0, 60);
    frame(2'b01, 2'b10, 1, 2'b01, 0, 61);
    repeat (5) drive(1, 1, 2'b00, 64'h7);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule